// File: doc/BRIEF.md
# Dual LED blink duty controller

This block drives two indicator LEDs, red and blue, from one free-running timebase. A prescaler divides the clock into phase ticks. A 3-bit phase counter splits each blink period into eight equal phases. Each LED is lit for a coded fraction of the period, always at the start of the period: all of it, half, a quarter or an eighth.

At full duty a channel can instead be pulsed by a fast strobe that is high one clock in four, which saves power while still looking steady. A global slowdown option doubles the length of every phase. A per-channel override forces an LED dark. The blue LED can also be gated by a live signal-detected input, so that it blinks only while a signal is present.

All configuration fields are captured together at the end of each blink period. A change therefore never cuts a period short. Synchronous reset clears the timebase and loads a configuration with both LEDs forced dark, which holds until the first period boundary.

Top module: `led_blink_ctrl`

## Requirements
- R1: While reset is high and after it falls, both LEDs are low, and they stay low for the whole first blink period whatever the configuration inputs hold.
- R2: Each phase is 2^PRESCALE_W cycles long and a period is eight phases. The duty code selects the lit phases: 2'b00 lights all eight, 2'b01 the first four, 2'b10 the first two and 2'b11 only the first. The lit time is one contiguous run starting at phase 0.
- R3: With the modulate bit set and duty code 2'b00, the LED is lit only on cycles where the two low prescaler bits are zero, which is one cycle in four. With any other duty code the modulate bit has no effect.
- R4: With the half-rate bit set, each phase lasts two prescaler wraps. The period and every lit run double in length, and the lit fraction is unchanged.
- R5: A channel's off-override bit keeps that LED low for the whole period. The other LED is not affected.
- R6: With the blue follow-detect bit set, the blue LED is lit per its duty only on cycles following a high sig_detect, and is low otherwise. The red LED ignores sig_detect.
- R7: All configuration inputs are sampled only at the end of phase 7. A change made mid-period leaves both LEDs behaving as before until the next period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| red_duty | input | 2 | Red duty code (00 full, 01 half, 10 quarter, 11 eighth) |
| blue_duty | input | 2 | Blue duty code, same coding |
| red_mod | input | 1 | Red power-saving pulse mode at full duty |
| blue_mod | input | 1 | Blue power-saving pulse mode at full duty |
| red_off | input | 1 | Force red LED off |
| blue_off | input | 1 | Force blue LED off |
| blue_follow | input | 1 | Gate blue LED with sig_detect |
| half_rate | input | 1 | Double the length of every phase |
| sig_detect | input | 1 | Signal-detected indication, sampled live |
| led_red | output | 1 | Red LED enable, active high |
| led_blue | output | 1 | Blue LED enable, active high |

## Verification
The bench counts lit cycles over whole periods and measures the longest lit run. A wrong duty decode or a shifted phase compare therefore shows up as a wrong count or a split run, and a half-rate bug shows as runs that did not double. It checks that modulate shrinks only full duty to a quarter; a design that applied it at every duty would light a half-duty LED for 8 cycles instead of 32. It synchronises on the blue LED's period start and changes an override mid-period, to catch a design that applies configuration at once. It also holds sig_detect low with follow mode on, to catch gating that leaks into the red channel or fails to darken blue.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;

    localparam int PHASE_W = 3;

    typedef struct packed {
        logic [1:0] duty;
        logic       modulate;
        logic       off;
    } chan_cfg_t;

    typedef struct packed {
        chan_cfg_t red;
        chan_cfg_t blue;
        logic      blue_follow;
        logic      half;
    } led_cfg_t;

    localparam chan_cfg_t CHAN_DARK = '{duty: 2'b00, modulate: 1'b0, off: 1'b1};
    localparam led_cfg_t  CFG_RESET = '{red: CHAN_DARK, blue: CHAN_DARK,
                                        blue_follow: 1'b0, half: 1'b0};

    // Lit phases per period: 8 >> code.
    function automatic logic in_lit_phase(input logic [1:0] code,
                                          input logic [PHASE_W-1:0] ph);
        logic [PHASE_W:0] limit;
        limit = (PHASE_W+1)'(1 << PHASE_W) >> code;
        return {1'b0, ph} < limit;
    endfunction

endpackage

// File: rtl/led_timebase.sv
module led_timebase
    import led_blink_pkg::*;
#(
    parameter int PRESCALE_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               half_en,
    output logic [PHASE_W-1:0] phase,
    output logic               tick,
    output logic               strobe,
    output logic               period_end
);
    localparam logic [PRESCALE_W-1:0] PRE_TOP = '1;
    localparam logic [PHASE_W-1:0]    PH_LAST = '1;

    typedef struct packed {
        logic [PRESCALE_W-1:0] pre;
        logic                  half;
        logic [PHASE_W-1:0]    phase;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic      step;

    always_comb begin
        st_d       = st_q;
        tick       = (st_q.pre == PRE_TOP);
        step       = tick && (!half_en || st_q.half);
        st_d.pre   = st_q.pre + 1'b1;
        if (!half_en)
            st_d.half = 1'b0;
        else if (tick)
            st_d.half = !st_q.half;
        if (step)
            st_d.phase = st_q.phase + 1'b1;
        period_end = step && (st_q.phase == PH_LAST);
        strobe     = (st_q.pre[1:0] == 2'b00);
        phase      = st_q.phase;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

endmodule

// File: rtl/led_channel.sv
module led_channel
    import led_blink_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  chan_cfg_t          cfg,
    input  logic               gate,
    input  logic [PHASE_W-1:0] phase,
    input  logic               strobe,
    output logic               led
);
    logic led_d, led_q;
    logic pulse_mode;

    always_comb begin
        pulse_mode = cfg.modulate && (cfg.duty == 2'b00);
        led_d = !cfg.off && gate && in_lit_phase(cfg.duty, phase)
                && (!pulse_mode || strobe);
    end

    always_ff @(posedge clk) begin
        if (rst)
            led_q <= 1'b0;
        else
            led_q <= led_d;
    end

    assign led = led_q;

endmodule

// File: rtl/led_blink_ctrl.sv
module led_blink_ctrl
    import led_blink_pkg::*;
#(
    parameter int PRESCALE_W = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] red_duty,
    input  logic [1:0] blue_duty,
    input  logic       red_mod,
    input  logic       blue_mod,
    input  logic       red_off,
    input  logic       blue_off,
    input  logic       blue_follow,
    input  logic       half_rate,
    input  logic       sig_detect,
    output logic       led_red,
    output logic       led_blue
);
    localparam int NCHAN = 2;

    led_cfg_t           cfg_d, cfg_q;
    logic [PHASE_W-1:0] phase;
    logic               tick;
    logic               strobe;
    logic               period_end;
    chan_cfg_t          ch_cfg [NCHAN];
    logic               ch_gate[NCHAN];
    logic               ch_led [NCHAN];

    led_timebase #(.PRESCALE_W(PRESCALE_W)) u_timebase (
        .clk        (clk),
        .rst        (rst),
        .half_en    (cfg_q.half),
        .phase      (phase),
        .tick       (tick),
        .strobe     (strobe),
        .period_end (period_end)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (period_end) begin
            cfg_d.red         = '{duty: red_duty,  modulate: red_mod,  off: red_off};
            cfg_d.blue        = '{duty: blue_duty, modulate: blue_mod, off: blue_off};
            cfg_d.blue_follow = blue_follow;
            cfg_d.half        = half_rate;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CFG_RESET;
        else
            cfg_q <= cfg_d;
    end

    always_comb begin
        ch_cfg[0]  = cfg_q.red;
        ch_gate[0] = 1'b1;
        ch_cfg[1]  = cfg_q.blue;
        ch_gate[1] = !cfg_q.blue_follow || sig_detect;
    end

    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        led_channel u_chan (
            .clk    (clk),
            .rst    (rst),
            .cfg    (ch_cfg[c]),
            .gate   (ch_gate[c]),
            .phase  (phase),
            .strobe (strobe),
            .led    (ch_led[c])
        );
    end

    assign led_red  = ch_led[0];
    assign led_blue = ch_led[1];

endmodule

// File: rtl/led_blink_ctrl_chk.sv
module led_blink_ctrl_chk
    import led_blink_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               led_red,
    input logic               led_blue,
    input logic               sig_detect,
    input led_cfg_t           cfg,
    input logic [PHASE_W-1:0] phase,
    input logic               tick,
    input logic               strobe
);
    // R1
    reset_dark_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!led_red && !led_blue));

    // R3
    red_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.red.modulate && cfg.red.duty == 2'b00 && !strobe) |=> !led_red);

    // R4
    phase_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != $past(phase)) |-> $past(tick));

    // R5
    red_forced_off_chk: assert property (@(posedge clk) disable iff (rst)
        cfg.red.off |=> !led_red);

    // R5
    blue_forced_off_chk: assert property (@(posedge clk) disable iff (rst)
        cfg.blue.off |=> !led_blue);

    // R6
    blue_detect_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.blue_follow && !sig_detect) |=> !led_blue);

    // R7
    cfg_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg) |-> (phase == '0));

endmodule

bind led_blink_ctrl led_blink_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .led_red    (led_red),
    .led_blue   (led_blue),
    .sig_detect (sig_detect),
    .cfg        (cfg_q),
    .phase      (phase),
    .tick       (tick),
    .strobe     (strobe)
);

// File: tb/led_blink_ctrl_test.sv
`timescale 1ns/1ps
module led_blink_ctrl_test;
    localparam int PW     = 3;
    localparam int PER    = 8 * (1 << PW);   // 64 cycles
    localparam int SETTLE = 4 * PER;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] red_duty = 2'b00, blue_duty = 2'b00;
    logic       red_mod = 1'b0, blue_mod = 1'b0;
    logic       red_off = 1'b0, blue_off = 1'b0;
    logic       blue_follow = 1'b0, half_rate = 1'b0, sig_detect = 1'b0;
    logic       led_red, led_blue;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    led_blink_ctrl #(.PRESCALE_W(PW)) uut (
        .clk(clk), .rst(rst),
        .red_duty(red_duty), .blue_duty(blue_duty),
        .red_mod(red_mod), .blue_mod(blue_mod),
        .red_off(red_off), .blue_off(blue_off),
        .blue_follow(blue_follow), .half_rate(half_rate),
        .sig_detect(sig_detect),
        .led_red(led_red), .led_blue(led_blue)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // Count lit cycles and longest lit run of one LED (0 red, 1 blue).
    task automatic measure(input int sel, input int n, output int cnt, output int run);
        int cur = 0;
        cnt = 0; run = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if ((sel == 0) ? led_red : led_blue) begin
                cnt++; cur++;
                if (cur > run) run = cur;
            end else begin
                cur = 0;
            end
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        int cnt_r, cnt_b, run;
        @(negedge clk);
        check("R1 red during reset", led_red, 0);
        check("R1 blue during reset", led_blue, 0);
        rst = 1'b0;
        measure(0, PER - 8, cnt_r, run);
        check("R1 red dark in first period", cnt_r, 0);
        wait_cycles(0);
        measure(1, 4, cnt_b, run);
        check("R1 blue dark in first period", cnt_b, 0);
    endtask

    task automatic t_duty;
        int cnt, run;
        for (int d = 0; d < 4; d++) begin
            @(negedge clk);
            red_duty = 2'(d);
            wait_cycles(SETTLE);
            measure(0, 2 * PER, cnt, run);
            check("R2 lit count", cnt, 2 * (PER >> d));
            if (d != 0) check("R2 lit run length", run, PER >> d);
        end
    endtask

    task automatic t_modulate;
        int cnt, run;
        @(negedge clk);
        red_duty = 2'b00; red_mod = 1'b1;
        wait_cycles(SETTLE);
        measure(0, PER, cnt, run);
        check("R3 modulate full duty count", cnt, PER / 4);
        check("R3 modulate pulse width", run, 1);
        @(negedge clk);
        red_duty = 2'b01;
        wait_cycles(SETTLE);
        measure(0, PER, cnt, run);
        check("R3 modulate ignored at half duty", cnt, PER / 2);
        @(negedge clk);
        red_mod = 1'b0;
    endtask

    task automatic t_half_rate;
        int cnt, run;
        @(negedge clk);
        half_rate = 1'b1; red_duty = 2'b11; blue_duty = 2'b01;
        wait_cycles(2 * SETTLE);
        measure(0, 2 * PER, cnt, run);
        check("R4 half-rate eighth count", cnt, PER / 4);
        check("R4 half-rate run doubled", run, PER / 4);
        measure(1, 2 * PER, cnt, run);
        check("R4 half-rate half-duty count", cnt, PER);
        @(negedge clk);
        half_rate = 1'b0; red_duty = 2'b00; blue_duty = 2'b00;
        wait_cycles(2 * SETTLE);
    endtask

    task automatic t_override;
        int cnt, run;
        @(negedge clk);
        red_off = 1'b1;
        wait_cycles(SETTLE);
        measure(0, PER, cnt, run);
        check("R5 red forced off", cnt, 0);
        measure(1, PER, cnt, run);
        check("R5 blue unaffected", cnt, PER);
        @(negedge clk);
        red_off = 1'b0;
    endtask

    task automatic t_detect;
        int cnt, run;
        @(negedge clk);
        blue_follow = 1'b1; sig_detect = 1'b0; red_duty = 2'b00; blue_duty = 2'b00;
        wait_cycles(SETTLE);
        measure(1, PER, cnt, run);
        check("R6 blue dark without detect", cnt, 0);
        measure(0, PER, cnt, run);
        check("R6 red ignores detect", cnt, PER);
        @(negedge clk);
        sig_detect = 1'b1; blue_duty = 2'b01;
        wait_cycles(SETTLE);
        measure(1, PER, cnt, run);
        check("R6 blue follows detect at duty", cnt, PER / 2);
        @(negedge clk);
        blue_follow = 1'b0; sig_detect = 1'b0;
    endtask

    task automatic t_boundary;
        int cnt, run, guard;
        logic prev;
        @(negedge clk);
        red_duty = 2'b00; blue_duty = 2'b11;
        wait_cycles(SETTLE);
        prev = led_blue; guard = 0;
        do begin
            prev = led_blue;
            @(negedge clk);
            guard++;
        end while (!(!prev && led_blue) && guard < 4 * PER);
        check("R7 found period start", int'(guard < 4 * PER), 1);
        red_off = 1'b1;
        measure(0, PER / 2, cnt, run);
        check("R7 change held until boundary", cnt, PER / 2);
        wait_cycles(PER);
        measure(0, PER, cnt, run);
        check("R7 change applied after boundary", cnt, 0);
        @(negedge clk);
        red_off = 1'b0;
    endtask

    initial begin
        t_reset();
        t_duty();
        t_modulate();
        t_half_rate();
        t_override();
        t_detect();
        t_boundary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule